// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits between a clock generator's control logic and its four differential output drivers. It watches a single dual-purpose pin: right after power-up that pin means "supply is good", and once it has been seen high it flips meaning and becomes an active-low power-down request. The block sequences the outputs through shutdown and restart. Shutdown parks every output low, holds them low for a while, and only then drops the oscillator/PLL enable. Restart raises that enable, waits for the PLL to report lock, and then releases the outputs.

A configuration bit chooses whether the configuration registers survive a power-down. When it is clear, a single-cycle clear strobe is issued as the oscillator turns off. Per-output enable bits and two test-mode bits pick each output's drive mode while running. A lock watchdog gives up on a PLL that never locks and reports an error.

All control inputs are plain level signals. There is no data stream, so no valid/ready handshake exists. The pin, the lock flag and the output-clock level are asynchronous and are synchronised inside the block.

Top module: `clkout_pd_seq`

## Requirements
- R1: Until the pin has been seen high after reset, the oscillator/PLL enable stays 0 and every output is held low, whatever the pin does. The first high level raises the enable.
- R2: The pin, the lock flag and the output-clock level each pass through a two-stage synchroniser. A pin change cannot alter any output in the cycle right after the change.
- R3: On power-down, every output is parked low first. The oscillator/PLL enable falls no earlier than HOLD_CYC reference cycles later.
- R4: A power-down request is acted on only after the synchronised pin has been low at two consecutive rising edges of the output clock. A shorter low pulse leaves the outputs running. Once parking has begun, the outputs stay low until the next restart.
- R5: After the enable rises, every output stays low until the synchronised lock flag is 1. Only then are the outputs released.
- R6: When `keep_cfg` is 0, `cfg_clear` pulses for exactly one cycle as the oscillator turns off. When it is 1, no pulse is produced.
- R7: Each output i has a 2-bit mode at `drv_mode[2i+1:2i]`, coded 00 run, 01 held low, 10 tri-state, 11 reference-divided. While running with test mode off, output i is 00 if `oe[i]` is 1 and 01 otherwise.
- R8: While running with `test_en`=1, every output is 10 if `test_sel`=0 and 11 if `test_sel`=1, overriding `oe`.
- R9: The outputs move into or out of the running state only when the synchronised output-clock level is low.
- R10: If lock is not seen within `lock_limit` reference cycles of the enable rising, `lock_err` goes to 1 and all outputs stay low until the next power-down. The following restart clears `lock_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| pwr_pin | input | 1 | Raw power-good / power-down pin (asynchronous) |
| pll_locked | input | 1 | PLL lock flag (asynchronous) |
| oclk | input | 1 | Output clock level (asynchronous) |
| keep_cfg | input | 1 | 1 keeps configuration across power-down |
| oe | input | N_OUT | Per-output enable |
| test_en | input | 1 | Test-mode entry |
| test_sel | input | 1 | Test mode: 0 tri-state, 1 reference-divided |
| lock_limit | input | LOCK_W | Lock timeout in reference cycles |
| drv_mode | output | 2*N_OUT | Per-output drive mode |
| osc_pll_en | output | 1 | Oscillator and PLL enable |
| cfg_clear | output | 1 | One-cycle configuration clear strobe |
| lock_err | output | 1 | Lock timeout error |

## Verification
The assertions rely on a few properties of the inputs.
- The output clock runs much slower than the reference clock, so its synchronised level has a clean low phase lasting several reference cycles.
- `keep_cfg`, `oe` and the test bits are static configuration, so they do not change in the cycle an assertion compares against.
- `lock_limit` is well above the synchroniser latency.

The stimulus follows these rules. It drives a free-running output clock with a six-cycle period, and it changes configuration only between sequencing phases. Power-down glitches are kept shorter than one output-clock period.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [1:0] {
    DRV_RUN    = 2'b00,
    DRV_LOW    = 2'b01,
    DRV_TRIS   = 2'b10,
    DRV_REFDIV = 2'b11
  } drv_e;

  typedef enum logic [2:0] {
    ST_WAITPG = 3'd0,
    ST_LOCK   = 3'd1,
    ST_RUN    = 3'd2,
    ST_STOP   = 3'd3,
    ST_OFF    = 3'd4,
    ST_FAIL   = 3'd5
  } seq_e;
endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HOLD_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_s,
  input  logic             lock_s,
  input  logic             oclk_s,
  input  logic             keep_cfg,
  input  logic [CNT_W-1:0] lock_limit,
  output logic             run,
  output logic             osc_en,
  output logic             lock_err,
  output logic             cfg_clear
);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  seq_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       edg_q, edg_d;
  logic             oclk_q;
  logic             clr_d;
  logic             rise;

  assign rise = oclk_s & ~oclk_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    edg_d = edg_q;
    clr_d = 1'b0;
    unique case (st_q)
      ST_WAITPG: if (pin_s) begin
        st_d  = ST_LOCK;
        cnt_d = '0;
      end
      ST_LOCK: begin
        if (!pin_s) begin
          st_d  = ST_STOP;
          cnt_d = '0;
        end else if (lock_s && !oclk_s) begin
          st_d  = ST_RUN;
          edg_d = '0;
        end else if (!lock_s && cnt_q >= lock_limit) begin
          st_d = ST_FAIL;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RUN: begin
        if (pin_s) begin
          edg_d = '0;
        end else if (edg_q == 2'd2 && !oclk_s) begin
          st_d  = ST_STOP;
          cnt_d = '0;
        end else if (rise && edg_q != 2'd2) begin
          edg_d = edg_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (cnt_q >= HOLD_LAST) begin
          st_d  = ST_OFF;
          clr_d = ~keep_cfg;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_OFF: if (pin_s) begin
        st_d  = ST_LOCK;
        cnt_d = '0;
      end
      ST_FAIL: if (!pin_s) begin
        st_d  = ST_STOP;
        cnt_d = '0;
      end
      default: st_d = ST_WAITPG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_WAITPG;
      cnt_q     <= '0;
      edg_q     <= '0;
      oclk_q    <= 1'b0;
      cfg_clear <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      edg_q     <= edg_d;
      oclk_q    <= oclk_s;
      cfg_clear <= clr_d;
    end
  end

  assign run      = (st_q == ST_RUN);
  assign lock_err = (st_q == ST_FAIL);
  assign osc_en   = (st_q == ST_LOCK) || (st_q == ST_RUN) ||
                    (st_q == ST_STOP) || (st_q == ST_FAIL);
endmodule

// File: rtl/pdseq_outmux.sv
module pdseq_outmux
  import pdseq_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic               run,
  input  logic [N_OUT-1:0]   oe,
  input  logic               test_en,
  input  logic               test_sel,
  output logic [2*N_OUT-1:0] drv_mode
);
  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      drv_e m;
      always_comb begin
        if (!run)         m = DRV_LOW;
        else if (test_en) m = test_sel ? DRV_REFDIV : DRV_TRIS;
        else if (oe[i])   m = DRV_RUN;
        else              m = DRV_LOW;
      end
      assign drv_mode[2*i+1:2*i] = m;
    end
  endgenerate
endmodule

// File: rtl/clkout_pd_seq.sv
module clkout_pd_seq
  import pdseq_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int LOCK_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_pin,
  input  logic               pll_locked,
  input  logic               oclk,
  input  logic               keep_cfg,
  input  logic [N_OUT-1:0]   oe,
  input  logic               test_en,
  input  logic               test_sel,
  input  logic [LOCK_W-1:0]  lock_limit,
  output logic [2*N_OUT-1:0] drv_mode,
  output logic               osc_pll_en,
  output logic               cfg_clear,
  output logic               lock_err
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw, synced;
  logic pin_s, lock_s, oclk_s, run;

  assign raw = {oclk, pll_locked, pwr_pin};
  assign {oclk_s, lock_s, pin_s} = synced;

  pdseq_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  pdseq_fsm #(.CNT_W(LOCK_W), .HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .lock_s(lock_s),
    .oclk_s(oclk_s), .keep_cfg(keep_cfg), .lock_limit(lock_limit),
    .run(run), .osc_en(osc_pll_en), .lock_err(lock_err),
    .cfg_clear(cfg_clear)
  );

  pdseq_outmux #(.N_OUT(N_OUT)) u_mux (
    .run(run), .oe(oe), .test_en(test_en), .test_sel(test_sel),
    .drv_mode(drv_mode)
  );
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk #(
  parameter int N_OUT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pin_s,
  input logic               lock_s,
  input logic               oclk_s,
  input logic               run,
  input logic               keep_cfg,
  input logic [N_OUT-1:0]   oe,
  input logic               test_en,
  input logic               test_sel,
  input logic [2*N_OUT-1:0] drv_mode,
  input logic               osc_pll_en,
  input logic               cfg_clear,
  input logic               lock_err
);
  localparam logic [2*N_OUT-1:0] ALL_LOW  = {N_OUT{2'b01}};
  localparam logic [2*N_OUT-1:0] ALL_TRIS = {N_OUT{2'b10}};
  localparam logic [2*N_OUT-1:0] ALL_REF  = {N_OUT{2'b11}};

  logic seen;
  logic all_low;
  logic [N_OUT-1:0] running_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= seen | pin_s;

  assign all_low = (drv_mode == ALL_LOW);

  always_comb
    for (int i = 0; i < N_OUT; i++)
      running_mask[i] = (drv_mode[2*i +: 2] == 2'b00);

  p_pg_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (!osc_pll_en && all_low));

  p_low_before_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_pll_en) |-> $past(all_low));

  p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_pll_en |-> all_low);

  p_lock_to_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(lock_s));

  p_clear_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |-> (!$past(keep_cfg) && !osc_pll_en));

  p_clear_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> !cfg_clear);

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !test_en) |-> ((running_mask & ~oe) == '0));

  p_test_tris_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && test_en && !test_sel) |-> (drv_mode == ALL_TRIS));

  p_test_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && test_en && test_sel) |-> (drv_mode == ALL_REF));

  p_edge_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run != $past(run)) |-> !$past(oclk_s));

  p_err_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> (all_low && osc_pll_en));
endmodule

bind clkout_pd_seq pdseq_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .lock_s(lock_s),
  .oclk_s(oclk_s), .run(run), .keep_cfg(keep_cfg), .oe(oe),
  .test_en(test_en), .test_sel(test_sel), .drv_mode(drv_mode),
  .osc_pll_en(osc_pll_en), .cfg_clear(cfg_clear), .lock_err(lock_err)
);

// File: tb/sim_clkout_pd_seq.sv
`timescale 1ns/1ps
module sim_clkout_pd_seq;
  localparam int N = 4;
  localparam int HOLD = 8;
  localparam logic [7:0] LOWS = 8'h55;

  logic clk = 0, rst_n = 0, pwr_pin = 0, pll_locked = 0, oclk = 0;
  logic keep_cfg = 1, test_en = 0, test_sel = 0;
  logic [N-1:0] oe = '1;
  logic [15:0] lock_limit = 16'd1000;
  logic [7:0] drv_mode;
  logic osc_pll_en, cfg_clear, lock_err;

  int checks = 0, fails = 0, cyc = 0, ocnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkout_pd_seq #(.N_OUT(N), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_pin(pwr_pin), .pll_locked(pll_locked),
    .oclk(oclk), .keep_cfg(keep_cfg), .oe(oe), .test_en(test_en),
    .test_sel(test_sel), .lock_limit(lock_limit), .drv_mode(drv_mode),
    .osc_pll_en(osc_pll_en), .cfg_clear(cfg_clear), .lock_err(lock_err)
  );

  always @(negedge clk) begin
    ocnt <= (ocnt == 2) ? 0 : ocnt + 1;
    if (ocnt == 2) oclk <= ~oclk;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] exp_drv(input logic [N-1:0] e, input logic t, input logic s);
    logic [7:0] r;
    for (int i = 0; i < N; i++) begin
      if (t)         r[2*i +: 2] = s ? 2'b11 : 2'b10;
      else if (e[i]) r[2*i +: 2] = 2'b00;
      else           r[2*i +: 2] = 2'b01;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  initial begin
    int lowt, offt, clrn;
    logic h0, h1, h2;
    void'($urandom(32'd5173));
    step(3);
    chk("R1 reset osc", osc_pll_en, 0);
    chk("R1 reset drive", drv_mode, LOWS);
    chk("R10 reset err", lock_err, 0);
    chk("R6 reset clear", cfg_clear, 0);
    @(negedge clk) rst_n = 1;
    step(20);
    chk("R1 pin low before good", osc_pll_en, 0);
    chk("R1 outputs low before good", drv_mode, LOWS);

    @(negedge clk) pwr_pin = 1;
    step(10);
    chk("R1 enable after good", osc_pll_en, 1);
    chk("R5 low while unlocked", drv_mode, LOWS);
    @(negedge clk) pll_locked = 1;
    step(20);
    chk("R5 released after lock", drv_mode, exp_drv(oe, 0, 0));

    for (int r = 0; r < 40; r++) begin
      @(negedge clk);
      oe = N'($urandom);
      test_en = ($urandom % 3) == 0;
      test_sel = $urandom % 2;
      step(1);
      chk(test_en ? "R8 random test" : "R7 random enables", drv_mode, exp_drv(oe, test_en, test_sel));
    end
    @(negedge clk) begin test_en = 1; test_sel = 0; end
    step(1); chk("R8 tri-state", drv_mode, 8'hAA);
    @(negedge clk) test_sel = 1;
    step(1); chk("R8 ref divided", drv_mode, 8'hFF);
    @(negedge clk) begin test_en = 0; oe = '0; end
    step(1); chk("R7 all disabled", drv_mode, LOWS);
    @(negedge clk) oe = 4'b1010;
    step(1); chk("R7 mixed", drv_mode, 8'h11);

    @(negedge clk) pwr_pin = 0;
    step(1); chk("R2 no effect next cycle", drv_mode, 8'h11);
    step(2);
    @(negedge clk) pwr_pin = 1;
    step(20);
    chk("R4 glitch ignored", drv_mode, 8'h11);
    chk("R4 glitch osc", osc_pll_en, 1);

    keep_cfg = 0;
    lowt = -1; offt = -1; clrn = 0; h0 = 0; h1 = 0; h2 = 0;
    @(negedge clk) pwr_pin = 0;
    for (int i = 0; i < 200; i++) begin
      step(1);
      h2 = h1; h1 = h0; h0 = oclk;
      if (lowt < 0 && drv_mode == LOWS) begin
        lowt = i;
        chk("R9 stop while oclk low", h2, 0);
      end
      if (offt < 0 && !osc_pll_en) offt = i;
      if (cfg_clear) clrn++;
      if (lowt >= 0 && drv_mode != LOWS) chk("R4 stays low", drv_mode, LOWS);
    end
    chk("R3 parked before off", (lowt >= 0 && offt > lowt), 1);
    chk("R3 hold gap", (offt - lowt >= HOLD), 1);
    chk("R6 one clear pulse", clrn, 1);
    chk("R4 low after pd", drv_mode, LOWS);

    keep_cfg = 1; lock_limit = 16'd50; pll_locked = 0;
    @(negedge clk) pwr_pin = 1;
    step(30);
    chk("R10 no early err", lock_err, 0);
    chk("R5 low unlocked", drv_mode, LOWS);
    step(50);
    chk("R10 timeout err", lock_err, 1);
    @(negedge clk) pll_locked = 1;
    step(20);
    chk("R10 err sticks", lock_err, 1);
    chk("R10 outputs low", drv_mode, LOWS);
    clrn = 0;
    @(negedge clk) pwr_pin = 0;
    for (int i = 0; i < 60; i++) begin
      step(1);
      if (cfg_clear) clrn++;
    end
    chk("R6 no clear when kept", clrn, 0);
    chk("R3 off after fail", osc_pll_en, 0);
    @(negedge clk) pwr_pin = 1;
    step(30);
    chk("R10 err cleared", lock_err, 0);
    chk("R5 run after relock", drv_mode, 8'h11);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule